// File: doc/BRIEF.md
# Instruction Cluster Dependence Classifier

This block watches the decoded instructions of one basic block as they arrive in program order, one per cycle. Each instruction may carry a destination register, up to two source registers and a flag that marks it as a memory access. For every source operand the block decides where the value comes from. The value may come from an earlier instruction of the same block, from before the block, or across a memory access. Instructions linked by local values are merged into clusters. At the end of the block the block reports each cluster's register footprint toward the rest of the program. It also reports whether the cluster can be run data-parallel, based on a per-register stride-prediction vector that the caller supplies.

A control state machine has three states. `ST_IDLE` is entered at reset. `ST_COLLECT` accepts instructions. `ST_REPORT` holds the results. The transitions are:

- start: `ST_IDLE` or `ST_REPORT` to `ST_COLLECT` on `blk_start`.
- restart: `ST_COLLECT` back to `ST_COLLECT` on `blk_start`.
- finish: `ST_COLLECT` to `ST_REPORT` on `blk_end` when `blk_start` is low.

Results are read through a query port. The caller drives an instruction index and gets back, combinationally, that instruction's membership, its two source edge codes, its cluster identifier, the cluster's three external register masks and the cluster's parallel flag.

Top module: `icc_classifier`

## Requirements
- R1: After reset `res_valid` is 0 and `res_count` is 0.
- R2: A source whose register was last written by an earlier instruction of the current block is coded LOCAL (1) when neither that producer nor the consumer has `ins_mem` set. Producer and consumer then report the same cluster identifier.
- R3: A source with no earlier writer in the block is coded EXTERNAL (2). A source whose valid bit is low is coded NONE (0).
- R4: A source with an in-block producer is coded MEMORY (3) when the producer or the consumer has `ins_mem` set. Such an edge never merges clusters.
- R5: A cluster identifier is the smallest instruction index of its group of instructions linked by LOCAL edges. When an instruction links two clusters, every member of both takes the smaller identifier.
- R6: For a cluster, the read set is the registers its members read with EXTERNAL edges. The written set is the registers whose final in-block writer is a member. `qry_ext_upd` is read AND written, `qry_ext_in` is read only, and `qry_ext_out` is written only.
- R7: `qry_parallel` is 1 exactly when every bit of `qry_ext_upd` is also set in `stride_hint`, where `stride_hint` is sampled in the cycle that ends the block.
- R8: `res_valid` rises one cycle after an accepted `blk_end`. It stays high with unchanged results until the next `blk_start`, and it is low in the cycle after `blk_start`.
- R9: `blk_start` clears all tables. An instruction presented in the same cycle becomes index 0 of the new block.
- R10: An instruction presented in the same cycle as `blk_end` is part of the block.
- R11: At most 16 instructions are kept per block. Later ones are ignored and `res_count` stays at 16.
- R12: `ins_valid` outside a block (`ST_IDLE` or `ST_REPORT`, without `blk_start`) leaves `res_count` and all query results unchanged.
- R13: When `blk_start` and `blk_end` arrive in the same cycle, the start wins. The block keeps collecting and `res_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| blk_start | input | 1 | Begins a new basic block |
| blk_end | input | 1 | Ends the current basic block |
| ins_valid | input | 1 | Instruction present this cycle |
| ins_mem | input | 1 | Instruction accesses memory |
| ins_dst_vld | input | 1 | Instruction writes a register |
| ins_dst | input | 5 | Destination register |
| ins_sa_vld | input | 1 | First source in use |
| ins_sa | input | 5 | First source register |
| ins_sb_vld | input | 1 | Second source in use |
| ins_sb | input | 5 | Second source register |
| stride_hint | input | 32 | Per-register stride-prediction flags |
| qry_idx | input | 4 | Instruction index to query |
| res_valid | output | 1 | Results valid |
| res_count | output | 5 | Instructions kept in the block |
| qry_member | output | 1 | Queried index is a kept instruction |
| qry_cid | output | 4 | Cluster identifier of the queried instruction |
| qry_edge_a | output | 2 | Edge code of first source |
| qry_edge_b | output | 2 | Edge code of second source |
| qry_ext_in | output | 32 | Cluster external-input registers |
| qry_ext_out | output | 32 | Cluster external-output registers |
| qry_ext_upd | output | 32 | Cluster external-updated registers |
| qry_parallel | output | 1 | Cluster is parallelizable |

## Verification
Two collisions can happen in one cycle: an instruction can arrive together with `blk_end`, and an instruction can arrive together with `blk_start`. Either way, classifying and merging must happen in the same cycle as the table clear or the state change. The bench drives both collisions on purpose. In each case it checks that the extra instruction appears in `res_count`, carries the expected edge codes, and leaves the expected cluster masks behind. A third collision, `blk_start` together with `blk_end`, is judged by `res_valid` staying low and by the following block's count.

// File: rtl/icc_pkg.sv
package icc_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE  = 2'd0,
        EDGE_LOCAL = 2'd1,
        EDGE_EXT   = 2'd2,
        EDGE_MEM   = 2'd3
    } edge_cls_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_REPORT  = 2'd2
    } icc_state_e;

endpackage

// File: rtl/icc_fsm.sv
module icc_fsm
    import icc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic blk_start,
    input  logic blk_end,
    output logic clear,
    output logic collecting,
    output logic end_take,
    output logic res_valid
);

    icc_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (blk_start) state_d = ST_COLLECT;
            ST_COLLECT: begin
                if (blk_start)    state_d = ST_COLLECT;
                else if (blk_end) state_d = ST_REPORT;
            end
            ST_REPORT:  if (blk_start) state_d = ST_COLLECT;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        clear      = blk_start;
        collecting = blk_start || (state_q == ST_COLLECT);
        end_take   = (state_q == ST_COLLECT) && blk_end && !blk_start;
        res_valid  = (state_q == ST_REPORT);
    end

endmodule

// File: rtl/icc_prod_table.sv
module icc_prod_table #(
    parameter int NREG = 32,
    parameter int NINS = 16,
    localparam int RW = $clog2(NREG),
    localparam int IW = $clog2(NINS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_reg,
    input  logic [IW-1:0] wr_idx,
    input  logic          wr_mem,
    input  logic [RW-1:0] ra,
    input  logic [RW-1:0] rb,
    output logic          hit_a,
    output logic [IW-1:0] idx_a,
    output logic          mem_a,
    output logic          hit_b,
    output logic [IW-1:0] idx_b,
    output logic          mem_b
);

    logic [NREG-1:0] vld_q;
    logic [NREG-1:0] mem_q;
    logic [IW-1:0]   idx_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q[g] <= 1'b0;
                mem_q[g] <= 1'b0;
                idx_q[g] <= '0;
            end else if (wr_en && (wr_reg == RW'(g))) begin
                vld_q[g] <= 1'b1;
                mem_q[g] <= wr_mem;
                idx_q[g] <= wr_idx;
            end else if (clear) begin
                vld_q[g] <= 1'b0;
            end
        end
    end

    always_comb begin
        hit_a = !clear && vld_q[ra];
        idx_a = idx_q[ra];
        mem_a = mem_q[ra];
        hit_b = !clear && vld_q[rb];
        idx_b = idx_q[rb];
        mem_b = mem_q[rb];
    end

endmodule

// File: rtl/icc_cluster_store.sv
module icc_cluster_store
    import icc_pkg::*;
#(
    parameter int NREG = 32,
    parameter int NINS = 16,
    localparam int RW = $clog2(NREG),
    localparam int IW = $clog2(NINS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            acc,
    input  logic [IW-1:0]   cur,
    input  logic            loc_a,
    input  logic            loc_b,
    input  logic [IW-1:0]   pa,
    input  logic [IW-1:0]   pb,
    input  logic [NREG-1:0] ext_rd,
    input  logic            wr_en,
    input  logic [RW-1:0]   wr_reg,
    input  edge_cls_e       cls_a,
    input  edge_cls_e       cls_b,
    input  logic [IW-1:0]   qry,
    output logic [IW-1:0]   q_cid,
    output edge_cls_e       q_cls_a,
    output edge_cls_e       q_cls_b,
    output logic [NREG-1:0] q_rd,
    output logic [NREG-1:0] q_wl
);

    logic [IW-1:0]   id_q  [NINS];
    logic [IW-1:0]   id_d  [NINS];
    logic [NREG-1:0] rd_q  [NINS];
    logic [NREG-1:0] rd_d  [NINS];
    logic [NREG-1:0] wl_q  [NINS];
    logic [NREG-1:0] wl_d  [NINS];
    edge_cls_e       ca_q  [NINS];
    edge_cls_e       cb_q  [NINS];

    logic [IW-1:0]   root_a, root_b, root_m;
    logic [NREG-1:0] wbit, rd_merge, wl_merge;

    // Union step: the surviving root is the smaller identifier.
    always_comb begin
        root_a = id_q[pa];
        root_b = id_q[pb];
        if (loc_a && loc_b) root_m = (root_a < root_b) ? root_a : root_b;
        else if (loc_a)     root_m = root_a;
        else if (loc_b)     root_m = root_b;
        else                root_m = cur;
        wbit     = wr_en ? (NREG'(1) << wr_reg) : '0;
        rd_merge = ext_rd | (loc_a ? rd_q[root_a] : '0) | (loc_b ? rd_q[root_b] : '0);
        wl_merge = (loc_a ? wl_q[root_a] : '0) | (loc_b ? wl_q[root_b] : '0);
    end

    always_comb begin
        for (int k = 0; k < NINS; k++) begin
            rd_d[k] = clear ? '0 : rd_q[k];
            wl_d[k] = clear ? '0 : wl_q[k];
            id_d[k] = id_q[k];
            if (acc) begin
                wl_d[k] = wl_d[k] & ~wbit;
                if (IW'(k) == root_m) begin
                    rd_d[k] = rd_merge;
                    wl_d[k] = (wl_merge & ~wbit) | wbit;
                end else if ((loc_a && IW'(k) == root_a) || (loc_b && IW'(k) == root_b)) begin
                    rd_d[k] = '0;
                    wl_d[k] = '0;
                end
                if (IW'(k) == cur) begin
                    id_d[k] = root_m;
                end else if ((loc_a && id_q[k] == root_a) || (loc_b && id_q[k] == root_b)) begin
                    id_d[k] = root_m;
                end
            end
        end
    end

    for (genvar g = 0; g < NINS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                id_q[g] <= '0;
                rd_q[g] <= '0;
                wl_q[g] <= '0;
                ca_q[g] <= EDGE_NONE;
                cb_q[g] <= EDGE_NONE;
            end else begin
                id_q[g] <= id_d[g];
                rd_q[g] <= rd_d[g];
                wl_q[g] <= wl_d[g];
                if (acc && cur == IW'(g)) begin
                    ca_q[g] <= cls_a;
                    cb_q[g] <= cls_b;
                end
            end
        end
    end

    always_comb begin
        q_cid   = id_q[qry];
        q_cls_a = ca_q[qry];
        q_cls_b = cb_q[qry];
        q_rd    = rd_q[q_cid];
        q_wl    = wl_q[q_cid];
    end

endmodule

// File: rtl/icc_classifier.sv
module icc_classifier
    import icc_pkg::*;
#(
    parameter int NREG = 32,
    parameter int NINS = 16,
    localparam int RW = $clog2(NREG),
    localparam int IW = $clog2(NINS),
    localparam int CW = $clog2(NINS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            blk_start,
    input  logic            blk_end,
    input  logic            ins_valid,
    input  logic            ins_mem,
    input  logic            ins_dst_vld,
    input  logic [RW-1:0]   ins_dst,
    input  logic            ins_sa_vld,
    input  logic [RW-1:0]   ins_sa,
    input  logic            ins_sb_vld,
    input  logic [RW-1:0]   ins_sb,
    input  logic [NREG-1:0] stride_hint,
    input  logic [IW-1:0]   qry_idx,
    output logic            res_valid,
    output logic [CW-1:0]   res_count,
    output logic            qry_member,
    output logic [IW-1:0]   qry_cid,
    output logic [1:0]      qry_edge_a,
    output logic [1:0]      qry_edge_b,
    output logic [NREG-1:0] qry_ext_in,
    output logic [NREG-1:0] qry_ext_out,
    output logic [NREG-1:0] qry_ext_upd,
    output logic            qry_parallel
);

    logic            clear, collecting, end_take;
    logic [CW-1:0]   cnt_q, cnt_eff;
    logic            acc;
    logic            hit_a, hit_b, pmem_a, pmem_b;
    logic [IW-1:0]   pidx_a, pidx_b;
    edge_cls_e       cls_a, cls_b;
    logic [NREG-1:0] ext_rd, stride_q, q_rd, q_wl;
    edge_cls_e       q_cls_a, q_cls_b;

    icc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .blk_start  (blk_start),
        .blk_end    (blk_end),
        .clear      (clear),
        .collecting (collecting),
        .end_take   (end_take),
        .res_valid  (res_valid)
    );

    always_comb begin
        cnt_eff = clear ? '0 : cnt_q;
        acc     = ins_valid && collecting && (cnt_eff < CW'(NINS));
    end

    icc_prod_table #(.NREG(NREG), .NINS(NINS)) u_ptab (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .wr_en  (acc && ins_dst_vld),
        .wr_reg (ins_dst),
        .wr_idx (cnt_eff[IW-1:0]),
        .wr_mem (ins_mem),
        .ra     (ins_sa),
        .rb     (ins_sb),
        .hit_a  (hit_a),
        .idx_a  (pidx_a),
        .mem_a  (pmem_a),
        .hit_b  (hit_b),
        .idx_b  (pidx_b),
        .mem_b  (pmem_b)
    );

    always_comb begin
        cls_a = EDGE_NONE;
        if (ins_sa_vld) begin
            if (!hit_a)                cls_a = EDGE_EXT;
            else if (pmem_a || ins_mem) cls_a = EDGE_MEM;
            else                       cls_a = EDGE_LOCAL;
        end
        cls_b = EDGE_NONE;
        if (ins_sb_vld) begin
            if (!hit_b)                cls_b = EDGE_EXT;
            else if (pmem_b || ins_mem) cls_b = EDGE_MEM;
            else                       cls_b = EDGE_LOCAL;
        end
        ext_rd = ((cls_a == EDGE_EXT) ? (NREG'(1) << ins_sa) : '0)
               | ((cls_b == EDGE_EXT) ? (NREG'(1) << ins_sb) : '0);
    end

    icc_cluster_store #(.NREG(NREG), .NINS(NINS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .acc     (acc),
        .cur     (cnt_eff[IW-1:0]),
        .loc_a   (acc && cls_a == EDGE_LOCAL),
        .loc_b   (acc && cls_b == EDGE_LOCAL),
        .pa      (pidx_a),
        .pb      (pidx_b),
        .ext_rd  (ext_rd),
        .wr_en   (ins_dst_vld),
        .wr_reg  (ins_dst),
        .cls_a   (cls_a),
        .cls_b   (cls_b),
        .qry     (qry_idx),
        .q_cid   (qry_cid),
        .q_cls_a (q_cls_a),
        .q_cls_b (q_cls_b),
        .q_rd    (q_rd),
        .q_wl    (q_wl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            stride_q <= '0;
        end else begin
            if (clear || acc) cnt_q <= cnt_eff + CW'(acc);
            if (end_take)     stride_q <= stride_hint;
        end
    end

    always_comb begin
        res_count    = cnt_q;
        qry_member   = CW'(qry_idx) < cnt_q;
        qry_edge_a   = q_cls_a;
        qry_edge_b   = q_cls_b;
        qry_ext_in   = q_rd & ~q_wl;
        qry_ext_out  = q_wl & ~q_rd;
        qry_ext_upd  = q_rd & q_wl;
        qry_parallel = ((q_rd & q_wl & ~stride_q) == '0);
    end

endmodule

// File: rtl/icc_checker.sv
module icc_checker #(
    parameter int NREG = 32,
    parameter int NINS = 16,
    localparam int IW = $clog2(NINS),
    localparam int CW = $clog2(NINS + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            blk_start,
    input logic            blk_end,
    input logic            res_valid,
    input logic [CW-1:0]   res_count,
    input logic [IW-1:0]   qry_idx,
    input logic            qry_member,
    input logic [IW-1:0]   qry_cid,
    input logic [NREG-1:0] qry_ext_upd,
    input logic            qry_parallel
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        res_count <= CW'(NINS)); // R11

    AST_CID_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        qry_member |-> (qry_cid <= qry_idx)); // R5

    AST_NO_UPD_PAR: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && qry_member && qry_ext_upd == '0) |-> qry_parallel); // R7

    AST_VALID_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_valid) |-> $past(blk_end)); // R8

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !blk_start) |=> (res_valid && $stable(res_count))); // R8

    AST_START_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        blk_start |=> !res_valid); // R13

endmodule

bind icc_classifier icc_checker #(.NREG(NREG), .NINS(NINS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .blk_start    (blk_start),
    .blk_end      (blk_end),
    .res_valid    (res_valid),
    .res_count    (res_count),
    .qry_idx      (qry_idx),
    .qry_member   (qry_member),
    .qry_cid      (qry_cid),
    .qry_ext_upd  (qry_ext_upd),
    .qry_parallel (qry_parallel)
);

// File: tb/icc_classifier_tb.sv
module icc_classifier_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        blk_start = 1'b0, blk_end = 1'b0, ins_valid = 1'b0, ins_mem = 1'b0;
    logic        ins_dst_vld = 1'b0, ins_sa_vld = 1'b0, ins_sb_vld = 1'b0;
    logic [4:0]  ins_dst = '0, ins_sa = '0, ins_sb = '0;
    logic [31:0] stride_hint = '0;
    logic [3:0]  qry_idx = '0;
    logic        res_valid, qry_member, qry_parallel;
    logic [4:0]  res_count;
    logic [3:0]  qry_cid;
    logic [1:0]  qry_edge_a, qry_edge_b;
    logic [31:0] qry_ext_in, qry_ext_out, qry_ext_upd;

    always #2 clk = ~clk;

    icc_classifier u_dut (
        .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .blk_end(blk_end),
        .ins_valid(ins_valid), .ins_mem(ins_mem), .ins_dst_vld(ins_dst_vld),
        .ins_dst(ins_dst), .ins_sa_vld(ins_sa_vld), .ins_sa(ins_sa),
        .ins_sb_vld(ins_sb_vld), .ins_sb(ins_sb), .stride_hint(stride_hint),
        .qry_idx(qry_idx), .res_valid(res_valid), .res_count(res_count),
        .qry_member(qry_member), .qry_cid(qry_cid), .qry_edge_a(qry_edge_a),
        .qry_edge_b(qry_edge_b), .qry_ext_in(qry_ext_in), .qry_ext_out(qry_ext_out),
        .qry_ext_upd(qry_ext_upd), .qry_parallel(qry_parallel)
    );

    int total = 0;
    int bad = 0;

    int          n_ins;
    bit          bdv[24], bsav[24], bsbv[24], bm[24];
    logic [4:0]  bd[24], bsa[24], bsb[24];
    logic [31:0] b_stride;

    int          e_cnt;
    int          e_cid[16], e_ca[16], e_cb[16];
    logic [31:0] e_in[16], e_out[16], e_upd[16];
    bit          e_par[16];

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic void build_expect();
        int pv[32];
        int pi[32];
        bit la[16], lb[16];
        int pa[16], pb[16];
        logic [31:0] xr[16], rd[16], wl[16];
        int root[16];
        e_cnt = (n_ins > 16) ? 16 : n_ins;
        for (int r = 0; r < 32; r++) begin pv[r] = 0; pi[r] = 0; end
        for (int i = 0; i < 16; i++) begin
            la[i] = 0; lb[i] = 0; pa[i] = 0; pb[i] = 0; xr[i] = 0;
            rd[i] = 0; wl[i] = 0; root[i] = i; e_ca[i] = 0; e_cb[i] = 0;
        end
        for (int i = 0; i < e_cnt; i++) begin
            if (bsav[i]) begin
                if (pv[bsa[i]] == 0) begin e_ca[i] = 2; xr[i] |= 32'(1) << bsa[i]; end
                else if (bm[pi[bsa[i]]] || bm[i]) e_ca[i] = 3;
                else begin e_ca[i] = 1; la[i] = 1; pa[i] = pi[bsa[i]]; end
            end
            if (bsbv[i]) begin
                if (pv[bsb[i]] == 0) begin e_cb[i] = 2; xr[i] |= 32'(1) << bsb[i]; end
                else if (bm[pi[bsb[i]]] || bm[i]) e_cb[i] = 3;
                else begin e_cb[i] = 1; lb[i] = 1; pb[i] = pi[bsb[i]]; end
            end
            if (bdv[i]) begin pv[bd[i]] = 1; pi[bd[i]] = i; end
        end
        for (int pass = 0; pass < 16; pass++) begin
            for (int i = 0; i < e_cnt; i++) begin
                if (la[i]) begin
                    int m = (root[i] < root[pa[i]]) ? root[i] : root[pa[i]];
                    root[i] = m; root[pa[i]] = m;
                end
                if (lb[i]) begin
                    int m = (root[i] < root[pb[i]]) ? root[i] : root[pb[i]];
                    root[i] = m; root[pb[i]] = m;
                end
            end
        end
        for (int i = 0; i < e_cnt; i++) rd[root[i]] |= xr[i];
        for (int r = 0; r < 32; r++) if (pv[r] != 0) wl[root[pi[r]]] |= 32'(1) << r;
        for (int i = 0; i < e_cnt; i++) begin
            e_cid[i] = root[i];
            e_in[i]  = rd[root[i]] & ~wl[root[i]];
            e_out[i] = wl[root[i]] & ~rd[root[i]];
            e_upd[i] = rd[root[i]] & wl[root[i]];
            e_par[i] = ((rd[root[i]] & wl[root[i]] & ~b_stride) == 0);
        end
    endfunction

    task automatic drive_ins(int i);
        ins_valid = 1'b1; ins_mem = bm[i]; ins_dst_vld = bdv[i]; ins_dst = bd[i];
        ins_sa_vld = bsav[i]; ins_sa = bsa[i]; ins_sb_vld = bsbv[i]; ins_sb = bsb[i];
    endtask

    task automatic idle_ins();
        ins_valid = 1'b0; ins_mem = 1'b0; ins_dst_vld = 1'b0; ins_sa_vld = 1'b0; ins_sb_vld = 1'b0;
    endtask

    // R9 (first_with_start) and R10 (end_with_last) collisions are chosen per call.
    task automatic run_block(bit first_with_start, bit end_with_last);
        int first;
        @(negedge clk);
        blk_start = 1'b1;
        if (first_with_start) drive_ins(0); else idle_ins();
        first = first_with_start ? 1 : 0;
        for (int i = first; i < n_ins; i++) begin
            @(negedge clk);
            blk_start = 1'b0;
            drive_ins(i);
            if (end_with_last && i == n_ins - 1) begin blk_end = 1'b1; stride_hint = b_stride; end
        end
        @(negedge clk);
        blk_start = 1'b0; idle_ins();
        if (!end_with_last) begin
            blk_end = 1'b1; stride_hint = b_stride;
            @(negedge clk);
        end
        blk_end = 1'b0;
        stride_hint = $urandom;
        build_expect();
    endtask

    task automatic check_all();
        chk("R8", "res_valid", 64'(res_valid), 64'd1);
        chk("R11", "res_count", 64'(res_count), 64'(e_cnt));
        for (int q = 0; q < 16; q++) begin
            qry_idx = 4'(q);
            #0.5;
            chk("R11", "member", 64'(qry_member), 64'(q < e_cnt));
            if (q < e_cnt) begin
                chk("R5", "cid", 64'(qry_cid), 64'(e_cid[q]));
                chk("R2", "edge_a", 64'(qry_edge_a), 64'(e_ca[q]));
                chk("R3", "edge_b", 64'(qry_edge_b), 64'(e_cb[q]));
                chk("R6", "ext_in", 64'(qry_ext_in), 64'(e_in[q]));
                chk("R6", "ext_out", 64'(qry_ext_out), 64'(e_out[q]));
                chk("R6", "ext_upd", 64'(qry_ext_upd), 64'(e_upd[q]));
                chk("R7", "parallel", 64'(qry_parallel), 64'(e_par[q]));
            end
        end
    endtask

    task automatic set_ins(int i, bit dv, int d, bit av, int a, bit bv, int b, bit m);
        bdv[i] = dv; bd[i] = 5'(d); bsav[i] = av; bsa[i] = 5'(a);
        bsbv[i] = bv; bsb[i] = 5'(b); bm[i] = m;
    endtask

    task automatic rand_block(int n);
        n_ins = n;
        for (int i = 0; i < 24; i++)
            set_ins(i, ($urandom % 5) != 0, $urandom % 8, ($urandom % 4) != 0, $urandom % 8,
                    ($urandom % 4) != 0, $urandom % 8, ($urandom % 7) == 0);
        b_stride = $urandom;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unused_seed;
        logic [4:0] held;
        unused_seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "res_valid at reset", 64'(res_valid), 64'd0);
        chk("R1", "res_count at reset", 64'(res_count), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "res_valid after reset", 64'(res_valid), 64'd0);

        // Directed: chain, memory edge, updated register
        n_ins = 4; b_stride = 32'h0;
        set_ins(0, 1, 1, 1, 2, 1, 3, 0);
        set_ins(1, 1, 4, 1, 1, 1, 5, 0);
        set_ins(2, 1, 6, 1, 4, 0, 0, 1);
        set_ins(3, 1, 2, 1, 6, 1, 2, 0);
        run_block(0, 0);
        check_all();
        qry_idx = 4'd1; #0.5;
        chk("R2", "chain local edge", 64'(qry_edge_a), 64'd1);
        qry_idx = 4'd2; #0.5;
        chk("R4", "load memory edge", 64'(qry_edge_a), 64'd3);
        chk("R4", "memory edge no merge", 64'(qry_cid), 64'd2);
        // R8 hold for several cycles, then drop on start
        held = res_count;
        repeat (5) @(negedge clk);
        chk("R8", "held valid", 64'(res_valid), 64'd1);
        chk("R8", "held count", 64'(res_count), 64'(held));

        // Directed merge of two clusters, updated register with stride prediction
        n_ins = 4; b_stride = 32'h0000_0002;
        set_ins(0, 1, 1, 1, 1, 0, 0, 0);
        set_ins(1, 1, 2, 1, 10, 0, 0, 0);
        set_ins(2, 1, 3, 1, 2, 1, 1, 0);
        set_ins(3, 0, 0, 0, 0, 0, 0, 0);
        run_block(0, 0);
        check_all();
        qry_idx = 4'd1; #0.5;
        chk("R5", "merged cid", 64'(qry_cid), 64'd0);
        chk("R7", "predicted update parallel", 64'(qry_parallel), 64'd1);
        chk("R6", "update reg r1", 64'(qry_ext_upd), 64'h2);

        // R12: instruction outside a block is ignored
        @(negedge clk);
        set_ins(20, 1, 9, 1, 1, 0, 0, 0);
        drive_ins(20);
        @(negedge clk);
        idle_ins();
        check_all();

        // R9 / R10 collisions
        rand_block(6);
        run_block(1, 1);
        check_all();

        // R11 overflow
        rand_block(20);
        run_block(0, 0);
        check_all();

        // R13 start and end together
        @(negedge clk);
        blk_start = 1'b1; blk_end = 1'b1;
        @(negedge clk);
        blk_start = 1'b0; blk_end = 1'b0;
        chk("R13", "no report", 64'(res_valid), 64'd0);
        n_ins = 1; b_stride = 32'h0;
        set_ins(0, 1, 3, 1, 4, 0, 0, 0);
        drive_ins(0);
        @(negedge clk);
        idle_ins(); blk_end = 1'b1; stride_hint = b_stride;
        @(negedge clk);
        blk_end = 1'b0;
        build_expect();
        check_all();

        // Random blocks
        for (int t = 0; t < 40; t++) begin
            rand_block(1 + ($urandom % 18));
            run_block(($urandom % 3) == 0 && n_ins > 1, ($urandom % 2) == 0 && n_ins > 1);
            check_all();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule